// File: doc/BRIEF.md
# Correlation Peak Finder

This block takes one measurement-matrix column per clock and forms the dot product of that column with a residual vector held inside the block. While the columns stream through, it keeps the column whose correlation has the largest absolute value. Once the last column of a scan has passed through the pipeline, it raises a one-cycle completion pulse. At that point the outputs hold the winning column index and the signed correlation of that column.

A scan has three steps:

- Software-side control loads the residual and issues a start pulse while the block is idle. Both may happen in the same cycle.
- The columns are streamed in any index order. Idle gaps between columns are allowed.
- The final column is marked with a last flag.

The arithmetic is a three-stage pipeline:

- Stage one forms every element product in parallel.
- Stage two forms parallel partial sums, each over a group of eight products.
- Stage three adds the partial sums, saturates the total and compares its magnitude with the running best.

A small controller has three states, and every other input depends on which state it is in:

- `ST_IDLE` moves to `ST_SCAN` on start.
- `ST_SCAN` moves to `ST_DRAIN` on a valid column flagged last.
- `ST_DRAIN` moves back to `ST_IDLE` in the cycle the last column's result reaches the outputs.

Top module: `corr_peak_finder`

## Requirements
- R1: After reset, `done` is 0, `best_idx` is 0 and `best_corr` is 0, and the block is idle.
- R2: Element i of a vector occupies bits [i*24 +: 24] as two's complement with 14 fraction bits. Each product is the exact 48-bit product shifted right arithmetically by 14 (rounding toward minus infinity). The sums are exact, and the total is saturated to the range [-8388608, 8388607].
- R3: During a scan a column is accepted in every cycle that `col_valid` is high, with gaps allowed. The result of a column presented in cycle c reaches the outputs in cycle c+3.
- R4: `start` is honoured only when idle. It clears `best_idx` and `best_corr` to 0 and opens a scan. A start pulse during a scan or drain has no effect.
- R5: `res_load` copies `res_vec` into the stored residual only when idle. Later columns use the stored value, and a load during a scan or drain has no effect.
- R6: `col_valid` outside a scan is ignored: no result and no `done` follow from it.
- R7: `best_corr` is the signed saturated correlation with the largest magnitude seen since start, and `best_idx` is that column's index. Both hold between updates.
- R8: When two magnitudes are equal, the lower column index wins, whatever order the columns arrive in.
- R9: `done` is a one-cycle pulse in cycle c+3 after the last column (presented in cycle c). The block is idle in that cycle, so a start in the `done` cycle is honoured.
- R10: The first result after a start is always taken, even when its magnitude is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear the running best and open a scan (idle only) |
| res_load | input | 1 | Capture `res_vec` as the residual (idle only) |
| res_vec | input | 1536 | Residual vector, 64 elements of 24 bits |
| col_valid | input | 1 | Column present this cycle |
| col_last | input | 1 | Marks the final column of the scan |
| col_idx | input | 8 | Index of the presented column |
| col_data | input | 1536 | Column vector, 64 elements of 24 bits |
| done | output | 1 | One-cycle pulse: scan result final |
| best_idx | output | 8 | Index of the current winning column |
| best_corr | output | 24 | Signed correlation of the winning column |

## Verification
Two things can land in the same cycle: the comparison of the last column and the completion report. The tie and sign scans make the last column decide the outcome, and the bench checks both `done` and the winner in the cycle c+3. A restart can also coincide with the `done` cycle. The bench drives `start` together with a fresh residual load in exactly that cycle, then checks that the outputs clear one cycle later and that the next scan uses the new residual. A reference model built from queues, written behaviourally, predicts `done`, `best_idx` and `best_corr` for every clock, and each clock's outputs are compared against it.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } cpf_state_e;

endpackage

// File: rtl/cpf_mult_row.sv
module cpf_mult_row #(
    parameter int N_ELEM = 64,
    parameter int DW     = 24,
    parameter int FRAC   = 14,
    parameter int IDW    = 8,
    localparam int PW    = 2 * DW - FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_take,
    input  logic                 in_last,
    input  logic [IDW-1:0]       in_idx,
    input  logic [N_ELEM*DW-1:0] col_vec,
    input  logic [N_ELEM*DW-1:0] res_vec,
    output logic                 out_valid,
    output logic                 out_last,
    output logic [IDW-1:0]       out_idx,
    output logic [N_ELEM*PW-1:0] out_prods
);

    // side-band travels with the products
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_idx   <= '0;
        end else begin
            out_valid <= in_take;
            out_last  <= in_take && in_last;
            if (in_take) begin
                out_idx <= in_idx;
            end
        end
    end

    for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
        logic signed [DW-1:0]   a_el;
        logic signed [DW-1:0]   b_el;
        logic signed [2*DW-1:0] full;

        assign a_el = col_vec[g*DW +: DW];
        assign b_el = res_vec[g*DW +: DW];
        assign full = a_el * b_el;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_prods[g*PW +: PW] <= '0;
            end else if (in_take) begin
                out_prods[g*PW +: PW] <= PW'(full >>> FRAC);
            end
        end
    end

endmodule

// File: rtl/cpf_part_sum.sv
module cpf_part_sum #(
    parameter int N_ELEM = 64,
    parameter int GSIZE  = 8,
    parameter int PW     = 34,
    parameter int IDW    = 8,
    localparam int N_GRP = N_ELEM / GSIZE,
    localparam int SW    = PW + $clog2(GSIZE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_last,
    input  logic [IDW-1:0]       in_idx,
    input  logic [N_ELEM*PW-1:0] in_prods,
    output logic                 out_valid,
    output logic                 out_last,
    output logic [IDW-1:0]       out_idx,
    output logic [N_GRP*SW-1:0]  out_sums
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_idx   <= '0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_valid && in_last;
            if (in_valid) begin
                out_idx <= in_idx;
            end
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic signed [SW-1:0] acc;

        always_comb begin
            logic signed [PW-1:0] term;
            acc = '0;
            for (int k = 0; k < GSIZE; k++) begin
                term = in_prods[(g*GSIZE + k)*PW +: PW];
                acc  = acc + SW'(term);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_sums[g*SW +: SW] <= '0;
            end else if (in_valid) begin
                out_sums[g*SW +: SW] <= acc;
            end
        end
    end

endmodule

// File: rtl/cpf_peak_track.sv
module cpf_peak_track #(
    parameter int N_GRP = 8,
    parameter int SW    = 37,
    parameter int DW    = 24,
    parameter int IDW   = 8,
    localparam int TW   = SW + $clog2(N_GRP)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic [IDW-1:0]      in_idx,
    input  logic [N_GRP*SW-1:0] in_sums,
    output logic                done,
    output logic [IDW-1:0]      best_idx,
    output logic [DW-1:0]       best_corr
);

    localparam logic signed [TW-1:0] HI_LIM = TW'((longint'(1) <<< (DW-1)) - 1);
    localparam logic signed [TW-1:0] LO_LIM = TW'(-(longint'(1) <<< (DW-1)));

    logic signed [TW-1:0] total;
    logic        [DW-1:0] sat_val;
    logic        [DW-1:0] cand_mag;
    logic        [DW-1:0] best_mag;
    logic                 have_q;
    logic                 wins;

    always_comb begin
        logic signed [SW-1:0] part;
        total = '0;
        for (int g = 0; g < N_GRP; g++) begin
            part  = in_sums[g*SW +: SW];
            total = total + TW'(part);
        end
    end

    always_comb begin
        if (total > HI_LIM) begin
            sat_val = HI_LIM[DW-1:0];
        end else if (total < LO_LIM) begin
            sat_val = LO_LIM[DW-1:0];
        end else begin
            sat_val = total[DW-1:0];
        end
        cand_mag = sat_val[DW-1] ? DW'(~sat_val + DW'(1)) : sat_val;
        wins = !have_q || (cand_mag > best_mag) ||
               ((cand_mag == best_mag) && (in_idx < best_idx));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            have_q    <= 1'b0;
            best_idx  <= '0;
            best_corr <= '0;
            best_mag  <= '0;
        end else begin
            done <= in_valid && in_last;
            if (clear) begin
                have_q    <= 1'b0;
                best_idx  <= '0;
                best_corr <= '0;
                best_mag  <= '0;
            end else if (in_valid && wins) begin
                have_q    <= 1'b1;
                best_idx  <= in_idx;
                best_corr <= sat_val;
                best_mag  <= cand_mag;
            end
        end
    end

endmodule

// File: rtl/corr_peak_finder.sv
module corr_peak_finder
    import cpf_pkg::*;
#(
    parameter int N_ELEM = 64,
    parameter int DW     = 24,
    parameter int FRAC   = 14,
    parameter int GSIZE  = 8,
    parameter int N_COL  = 256,
    localparam int IDW   = $clog2(N_COL),
    localparam int VW    = N_ELEM * DW,
    localparam int PW    = 2 * DW - FRAC,
    localparam int N_GRP = N_ELEM / GSIZE,
    localparam int SW    = PW + $clog2(GSIZE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           res_load,
    input  logic [VW-1:0]  res_vec,
    input  logic           col_valid,
    input  logic           col_last,
    input  logic [IDW-1:0] col_idx,
    input  logic [VW-1:0]  col_data,
    output logic           done,
    output logic [IDW-1:0] best_idx,
    output logic [DW-1:0]  best_corr
);

    cpf_state_e st_q;
    cpf_state_e st_d;

    logic          take;
    logic          clear;
    logic          load_ok;
    logic [VW-1:0] res_q;

    logic                m_valid;
    logic                m_last;
    logic [IDW-1:0]      m_idx;
    logic [N_ELEM*PW-1:0] m_prods;

    logic                ps_valid;
    logic                ps_last;
    logic [IDW-1:0]      ps_idx;
    logic [N_GRP*SW-1:0] ps_sums;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start)                 st_d = ST_SCAN;
            ST_SCAN:  if (col_valid && col_last) st_d = ST_DRAIN;
            ST_DRAIN: if (ps_valid && ps_last)   st_d = ST_IDLE;
            default:                             st_d = ST_IDLE;
        endcase
    end

    // state-decoded controls
    always_comb begin
        take    = (st_q == ST_SCAN) && col_valid;
        clear   = (st_q == ST_IDLE) && start;
        load_ok = (st_q == ST_IDLE) && res_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (load_ok) begin
            res_q <= res_vec;
        end
    end

    cpf_mult_row #(
        .N_ELEM (N_ELEM),
        .DW     (DW),
        .FRAC   (FRAC),
        .IDW    (IDW)
    ) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_take   (take),
        .in_last   (col_last),
        .in_idx    (col_idx),
        .col_vec   (col_data),
        .res_vec   (res_q),
        .out_valid (m_valid),
        .out_last  (m_last),
        .out_idx   (m_idx),
        .out_prods (m_prods)
    );

    cpf_part_sum #(
        .N_ELEM (N_ELEM),
        .GSIZE  (GSIZE),
        .PW     (PW),
        .IDW    (IDW)
    ) u_psum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (m_valid),
        .in_last   (m_last),
        .in_idx    (m_idx),
        .in_prods  (m_prods),
        .out_valid (ps_valid),
        .out_last  (ps_last),
        .out_idx   (ps_idx),
        .out_sums  (ps_sums)
    );

    cpf_peak_track #(
        .N_GRP (N_GRP),
        .SW    (SW),
        .DW    (DW),
        .IDW   (IDW)
    ) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .in_valid  (ps_valid),
        .in_last   (ps_last),
        .in_idx    (ps_idx),
        .in_sums   (ps_sums),
        .done      (done),
        .best_idx  (best_idx),
        .best_corr (best_corr)
    );

endmodule

// File: rtl/cpf_checker.sv
module cpf_checker
    import cpf_pkg::*;
#(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          col_valid,
    input logic          col_last,
    input logic          done,
    input logic [DW-1:0] best_corr,
    input cpf_state_e    st
);

    logic [DW-1:0] mag;
    assign mag = best_corr[DW-1] ? DW'(~best_corr + DW'(1)) : best_corr;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    last_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_last && st == ST_SCAN) |-> ##3 done);

    // R4
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st == ST_IDLE) |=> (best_corr == '0 && st == ST_SCAN));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start) |=> (st == ST_IDLE && !done));

    // R7
    mag_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && st == ST_IDLE) |=> (mag >= $past(mag)));

endmodule

bind corr_peak_finder cpf_checker #(.DW(DW)) u_cpf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .col_valid (col_valid),
    .col_last  (col_last),
    .done      (done),
    .best_corr (best_corr),
    .st        (st_q)
);

// File: tb/corr_peak_finder_bench.sv
module corr_peak_finder_bench;

    localparam int N  = 64;
    localparam int DW = 24;
    localparam int FR = 14;
    localparam int IW = 8;
    localparam int VW = N * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          res_load = 1'b0;
    logic [VW-1:0] res_vec = '0;
    logic          col_valid = 1'b0;
    logic          col_last = 1'b0;
    logic [IW-1:0] col_idx = '0;
    logic [VW-1:0] col_data = '0;
    logic          done;
    logic [IW-1:0] best_idx;
    logic [DW-1:0] best_corr;

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;
    int wd = 0;

    always #2.5ns clk = ~clk;

    corr_peak_finder u_corr_peak_finder (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .res_load  (res_load),
        .res_vec   (res_vec),
        .col_valid (col_valid),
        .col_last  (col_last),
        .col_idx   (col_idx),
        .col_data  (col_data),
        .done      (done),
        .best_idx  (best_idx),
        .best_corr (best_corr)
    );

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] fill(int v);
        logic [VW-1:0] r;
        for (int i = 0; i < N; i++) r[i*DW +: DW] = DW'(v);
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd(int span);
        logic [VW-1:0] r;
        for (int i = 0; i < N; i++)
            r[i*DW +: DW] = DW'(int'($urandom_range(2*span, 0)) - span);
        return r;
    endfunction

    function automatic longint mdot(logic [VW-1:0] c, logic [VW-1:0] r);
        longint s = 0;
        for (int i = 0; i < N; i++) begin
            longint a, b, p;
            a = longint'($signed(c[i*DW +: DW]));
            b = longint'($signed(r[i*DW +: DW]));
            p = (a * b) >>> FR;
            s += p;
        end
        if (s > 8388607) s = 8388607;
        if (s < -8388608) s = -8388608;
        return s;
    endfunction

    // ---------------- reference model ----------------
    typedef struct {
        int     due;
        int     idx;
        longint val;
        bit     last;
    } ent_t;

    ent_t          q[$];
    int            mst;      // 0 idle, 1 scan, 2 drain
    int            cyc;
    int            m_idx;
    longint        m_val;
    longint        m_mag;
    bit            m_have;
    bit            m_done;
    logic [VW-1:0] m_res;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            mst = 0; cyc = 0; m_idx = 0; m_val = 0; m_mag = 0;
            m_have = 0; m_done = 0; m_res = '0;
        end else begin
            int old;
            cyc++;
            old = mst;
            m_done = 0;
            while (q.size() > 0 && q[0].due == cyc) begin
                ent_t e;
                longint mg;
                e = q.pop_front();
                mg = (e.val < 0) ? -e.val : e.val;
                if (!m_have || mg > m_mag || (mg == m_mag && e.idx < m_idx)) begin
                    m_idx = e.idx; m_val = e.val; m_mag = mg;
                end
                m_have = 1;
                if (e.last) begin
                    m_done = 1;
                    mst = 0;
                end
            end
            if (old == 0) begin
                if (res_load) m_res = res_vec;
                if (start) begin
                    m_idx = 0; m_val = 0; m_mag = 0; m_have = 0;
                    mst = 1;
                end
            end else if (old == 1 && col_valid) begin
                ent_t n;
                n.due = cyc + 2;
                n.idx = int'(col_idx);
                n.val = mdot(col_data, m_res);
                n.last = col_last;
                q.push_back(n);
                if (col_last) mst = 2;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(done == m_done, "R9 done vs model", longint'(done), longint'(m_done));
            chk(int'(best_idx) == m_idx, "R7 best_idx vs model", longint'(best_idx), m_idx);
            chk(longint'($signed(best_corr)) == m_val, "R2 best_corr vs model",
                longint'($signed(best_corr)), m_val);
        end
    end

    // watchdog
    always @(negedge clk) begin
        wd++;
        if (wd > 150000 && !fin) begin
            fin = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog R9 act=%0d exp=%0d", wd, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step_idle();
        @(negedge clk);
        start = 0; res_load = 0; col_valid = 0; col_last = 0;
    endtask

    task automatic put_col(int idx, logic [VW-1:0] d, bit last);
        @(negedge clk);
        start = 0; res_load = 0;
        col_valid = 1; col_idx = IW'(idx); col_data = d; col_last = last;
    endtask

    task automatic begin_scan(logic [VW-1:0] r);
        @(negedge clk);
        col_valid = 0; col_last = 0;
        res_load = 1; res_vec = r; start = 1;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            start = 0; res_load = 0; col_valid = 0; col_last = 0;
            if (done) begin
                lat = n;
                break;
            end
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done after reset", longint'(done), 0);
        chk(best_idx == '0, "R1 best_idx after reset", longint'(best_idx), 0);
        chk(best_corr == '0, "R1 best_corr after reset", longint'(best_corr), 0);

        // R3 random scan with gaps, latency of the last column
        begin_scan(rnd(40000));
        for (int i = 0; i < 256; i++) begin
            if (i % 7 == 3) step_idle();
            put_col(i, rnd(40000), i == 255);
        end
        wait_done(lat);
        chk(lat == 3, "R3 last-column latency", lat, 3);

        // R8 tie resolution, arrival order 20, 9, 5, 30
        begin_scan(fill(16384));
        put_col(20, fill(8192), 0);
        put_col(9, fill(-8192), 0);
        put_col(5, fill(8192), 0);
        put_col(30, fill(4096), 1);
        wait_done(lat);
        chk(int'(best_idx) == 5, "R8 tie lower index", longint'(best_idx), 5);
        chk(longint'($signed(best_corr)) == 524288, "R7 tie winner value",
            longint'($signed(best_corr)), 524288);

        // R7 signed winner reported
        begin_scan(fill(16384));
        put_col(9, fill(-8192), 0);
        put_col(20, fill(8192), 1);
        wait_done(lat);
        chk(int'(best_idx) == 9, "R8 earlier lower index kept", longint'(best_idx), 9);
        chk(longint'($signed(best_corr)) == -524288, "R7 negative winner",
            longint'($signed(best_corr)), -524288);

        // R2 floor rounding of products
        begin_scan(fill(1));
        put_col(3, fill(-1), 1);
        wait_done(lat);
        chk(longint'($signed(best_corr)) == -64, "R2 floor of products",
            longint'($signed(best_corr)), -64);

        // R2 saturation both ways; negative limit has larger magnitude
        begin_scan(fill(8388607));
        put_col(1, fill(8388607), 0);
        put_col(2, fill(-8388608), 1);
        wait_done(lat);
        chk(int'(best_idx) == 2, "R2 saturated winner idx", longint'(best_idx), 2);
        chk(longint'($signed(best_corr)) == -8388608, "R2 negative saturation",
            longint'($signed(best_corr)), -8388608);

        // R6 columns while idle are ignored
        put_col(50, fill(8192), 1);
        put_col(51, fill(8192), 1);
        step_idle();
        step_idle();
        step_idle();
        step_idle();
        chk(done == 1'b0, "R6 no done from idle columns", longint'(done), 0);
        chk(int'(best_idx) == 2, "R6 best_idx untouched", longint'(best_idx), 2);

        // R4 / R5 start and load ignored during a scan
        begin_scan(fill(16384));
        put_col(40, fill(8192), 0);
        @(negedge clk);
        col_valid = 0; col_last = 0;
        res_load = 1; res_vec = fill(32768); start = 1;
        put_col(41, fill(6144), 1);
        wait_done(lat);
        chk(int'(best_idx) == 40, "R4 start in scan ignored", longint'(best_idx), 40);
        chk(longint'($signed(best_corr)) == 524288, "R5 load in scan ignored",
            longint'($signed(best_corr)), 524288);

        // R9 restart in the done cycle, then R10 zero result taken
        begin_scan(fill(16384));
        put_col(60, fill(8192), 1);
        step_idle();
        step_idle();
        @(negedge clk);
        chk(done == 1'b1, "R9 done in cycle c+3", longint'(done), 1);
        chk(int'(best_idx) == 60, "R7 winner at done", longint'(best_idx), 60);
        col_valid = 0; col_last = 0;
        res_load = 1; res_vec = '0; start = 1;
        step_idle();
        chk(best_corr == '0 && best_idx == '0, "R4 clear on restart in done cycle",
            longint'(best_corr), 0);
        put_col(77, fill(8192), 1);
        wait_done(lat);
        chk(int'(best_idx) == 77, "R10 zero first result taken", longint'(best_idx), 77);
        chk(best_corr == '0, "R5 new residual used", longint'(best_corr), 0);

        step_idle();
        step_idle();
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule